// File: doc/BRIEF.md
# Paged Address Translation Unit

This block maps a 16-bit virtual address onto a 16-bit physical address using a sixteen-entry page table held in flip-flops. The upper four address bits select a page and the lower twelve bits pass through unchanged as the offset within a 4 KiB page. Each table entry holds a 4-bit frame number and five flags: present, read-only, referenced, modified and no-cache. An access either returns the translated address with its no-cache flag, or it returns a fault code. The result appears one clock after the request.

Each successful access updates the flags of the entry it used. Any successful access sets the referenced flag, and a successful write also sets the modified flag. A faulting access leaves the table as it was. A configuration port lets privileged software load a whole entry and read any entry back. When software writes an entry in the same cycle that an access uses it, the software value wins and the automatic flag update for that entry is dropped.

Top module: `page_xlate`

## Requirements
- R1: A successful access returns `rsp_paddr` = {frame number of the entry selected by `req_vaddr[15:12]`, `req_vaddr[11:0]`} with `rsp_fault` = 00.
- R2: An access to an entry whose present bit (bit 4) is 0 returns `rsp_fault` = 01. The fault code 11 never appears.
- R3: A write (`req_write`=1) to a present entry whose read-only bit (bit 5) is 1 returns `rsp_fault` = 10. A read of such an entry translates normally.
- R4: A successful read or write sets the referenced bit (bit 6) of the entry it used.
- R5: A successful write sets the modified bit (bit 7). A successful read leaves that bit unchanged.
- R6: On a successful access, `rsp_nocache` equals the no-cache bit (bit 8) of the entry.
- R7: A faulting access leaves the entry unchanged and drives `rsp_paddr` = 0 and `rsp_nocache` = 0.
- R8: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high. Back-to-back requests each get a response.
- R9: If `cfg_we` writes the same entry that an access uses in that cycle, the entry takes exactly `cfg_wdata`. The response is computed from the entry's previous value.
- R10: After reset every entry is zero (not present), and `rsp_valid` is 0.
- R11: `cfg_rdata` shows the entry selected by `cfg_idx` in the same cycle, with the entry layout {no-cache, modified, referenced, read-only, present, frame[3:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_vaddr | input | 16 | Virtual address |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_fault | output | 2 | 00 none, 01 not present, 10 protection |
| rsp_paddr | output | 16 | Physical address; 0 on a fault |
| rsp_nocache | output | 1 | No-cache flag of the entry used; 0 on a fault |
| cfg_we | input | 1 | Software entry write strobe |
| cfg_idx | input | 4 | Entry index for software read and write |
| cfg_wdata | input | 9 | Entry value to write |
| cfg_rdata | output | 9 | Entry value at `cfg_idx` |

## Verification
The assertions assume that the inputs are free of X while reset is released, and that each request holds its address and direction for the whole cycle in which it is sampled. The offset check relies on the request address from the previous cycle, so it assumes no gap between a request and the sampling of its response. The bench drives every input on the falling edge, holds it steady across the rising edge, and only removes it at the next falling edge. This keeps every request and software write inside those assumptions, including the back-to-back requests and the case where a software write collides with an access.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int VA_W    = 16,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [VA_W-1:0]            req_vaddr,
  output logic                       rsp_valid,
  output logic [1:0]                 rsp_fault,
  output logic [FRAME_W+OFF_W-1:0]   rsp_paddr,
  output logic                       rsp_nocache,
  input  logic                       cfg_we,
  input  logic [VA_W-OFF_W-1:0]      cfg_idx,
  input  logic [FRAME_W+4:0]         cfg_wdata,
  output logic [FRAME_W+4:0]         cfg_rdata
);
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int NPAGE   = 1 << VPN_W;
  localparam int ENT_W   = FRAME_W + 5;
  localparam int PA_W    = FRAME_W + OFF_W;
  localparam int B_PRES  = FRAME_W;
  localparam int B_RO    = FRAME_W + 1;
  localparam int B_REF   = FRAME_W + 2;
  localparam int B_MOD   = FRAME_W + 3;
  localparam int B_NC    = FRAME_W + 4;

  localparam logic [1:0] F_NONE = 2'b00;
  localparam logic [1:0] F_ABS  = 2'b01;
  localparam logic [1:0] F_PROT = 2'b10;

  logic [ENT_W-1:0] tbl [NPAGE];
  logic [VPN_W-1:0] vpn;
  logic [ENT_W-1:0] cur;
  logic [1:0]       fault_c;
  logic             hit_ok;

  assign vpn     = req_vaddr[VA_W-1:OFF_W];
  assign cur     = tbl[vpn];
  assign fault_c = !cur[B_PRES]                ? F_ABS  :
                   (req_write && cur[B_RO])    ? F_PROT : F_NONE;
  assign hit_ok  = req_valid && (fault_c == F_NONE);
  assign cfg_rdata = tbl[cfg_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAGE; i++) tbl[i] <= '0;
    end else begin
      for (int i = 0; i < NPAGE; i++) begin
        if (cfg_we && cfg_idx == VPN_W'(i)) begin
          tbl[i] <= cfg_wdata;
        end else if (hit_ok && vpn == VPN_W'(i)) begin
          tbl[i][B_REF] <= 1'b1;
          if (req_write) tbl[i][B_MOD] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_fault   <= F_NONE;
      rsp_paddr   <= '0;
      rsp_nocache <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_fault   <= req_valid ? fault_c : F_NONE;
      rsp_paddr   <= hit_ok ? PA_W'({cur[FRAME_W-1:0], req_vaddr[OFF_W-1:0]}) : '0;
      rsp_nocache <= hit_ok && cur[B_NC];
    end
  end
endmodule

module page_xlate_chk #(
  parameter int VA_W    = 16,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_write,
  input logic [OFF_W-1:0]         req_off,
  input logic                     rsp_valid,
  input logic [1:0]               rsp_fault,
  input logic [FRAME_W+OFF_W-1:0] rsp_paddr,
  input logic                     rsp_nocache
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R8
  AST_RSP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R8
  AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'b11); // R2
  AST_PROT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'b10) |-> $past(req_write)); // R3
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'b00) |-> (rsp_paddr == '0 && !rsp_nocache)); // R7
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'b00) |-> rsp_paddr[OFF_W-1:0] == $past(req_off)); // R1
endmodule

bind page_xlate page_xlate_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_off(req_vaddr[OFF_W-1:0]), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr), .rsp_nocache(rsp_nocache)
);

// File: tb/page_xlate_tb_top.sv
module page_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_vaddr = '0;
  logic        rsp_valid, rsp_nocache;
  logic [1:0]  rsp_fault;
  logic [15:0] rsp_paddr;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [8:0]  cfg_wdata = '0;
  logic [8:0]  cfg_rdata;

  int errs = 0, checks = 0;
  localparam logic [8:0] REF = 9'h040, MOD = 9'h080;

  always #5 clk = ~clk;

  page_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .rsp_nocache(rsp_nocache), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  function automatic logic [8:0] mk(input logic nc, input logic ro, input logic pr, input logic [3:0] fr);
    return {nc, 1'b0, 1'b0, ro, pr, fr};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] idx, input logic [8:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic entry_is(input string req, input logic [3:0] idx, input logic [8:0] exp);
    cfg_idx = idx;
    #1;
    chk(req, 32'(cfg_rdata), 32'(exp));
  endtask

  task automatic access(input logic w, input logic [15:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rsp_is(input string req, input logic [1:0] f, input logic [15:0] pa, input logic nc);
    chk({req, " valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " fault"}, 32'(rsp_fault), 32'(f));
    chk({req, " paddr"}, 32'(rsp_paddr), 32'(pa));
    chk({req, " nocache"}, 32'(rsp_nocache), 32'(nc));
  endtask

  task automatic t_reset;
    chk("R10 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    entry_is("R10 entry 0 after reset", 4'd0, 9'h0);
    entry_is("R10 entry 15 after reset", 4'd15, 9'h0);
  endtask

  task automatic t_not_present;
    access(1'b0, 16'h5123);
    rsp_is("R2 absent page", 2'b01, 16'h0, 1'b0);
    entry_is("R7 absent entry untouched", 4'd5, 9'h0);
    @(negedge clk);
    chk("R8 valid drops", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_translate;
    cfg_write(4'd2, mk(1'b0, 1'b0, 1'b1, 4'h9));
    entry_is("R11 readback", 4'd2, mk(1'b0, 1'b0, 1'b1, 4'h9));
    access(1'b0, 16'h2ABC);
    rsp_is("R1 read translate", 2'b00, 16'h9ABC, 1'b0);
    entry_is("R4 R5 read sets ref only", 4'd2, mk(1'b0, 1'b0, 1'b1, 4'h9) | REF);
  endtask

  task automatic t_write_dirty;
    cfg_write(4'd7, mk(1'b0, 1'b0, 1'b1, 4'h3));
    access(1'b1, 16'h7123);
    rsp_is("R1 write translate", 2'b00, 16'h3123, 1'b0);
    entry_is("R5 write sets ref and mod", 4'd7, mk(1'b0, 1'b0, 1'b1, 4'h3) | REF | MOD);
  endtask

  task automatic t_readonly;
    cfg_write(4'hA, mk(1'b1, 1'b1, 1'b1, 4'hF));
    access(1'b0, 16'hA00F);
    rsp_is("R3 R6 read of read-only page", 2'b00, 16'hF00F, 1'b1);
    cfg_write(4'hA, mk(1'b1, 1'b1, 1'b1, 4'hF));
    access(1'b1, 16'hA010);
    rsp_is("R3 R7 write to read-only page", 2'b10, 16'h0, 1'b0);
    entry_is("R7 protected entry untouched", 4'hA, mk(1'b1, 1'b1, 1'b1, 4'hF));
  endtask

  task automatic t_back2back;
    cfg_write(4'd1, mk(1'b0, 1'b0, 1'b1, 4'h4));
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_vaddr = 16'h1001;
    @(negedge clk);
    rsp_is("R8 first of pair", 2'b00, 16'h4001, 1'b0);
    req_vaddr = 16'hE002;
    @(negedge clk);
    req_valid = 1'b0;
    rsp_is("R8 second of pair", 2'b01, 16'h0, 1'b0);
    @(negedge clk);
    chk("R8 valid drops after pair", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_priority;
    cfg_write(4'd3, mk(1'b0, 1'b0, 1'b1, 4'h1));
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_vaddr = 16'h3456;
    cfg_we = 1'b1; cfg_idx = 4'd3; cfg_wdata = mk(1'b1, 1'b0, 1'b1, 4'h6);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; cfg_we = 1'b0;
    rsp_is("R9 response from old entry", 2'b00, 16'h1456, 1'b0);
    entry_is("R9 software value wins", 4'd3, mk(1'b1, 1'b0, 1'b1, 4'h6));
    access(1'b0, 16'h3FFF);
    rsp_is("R9 R6 new entry in use", 2'b00, 16'h6FFF, 1'b1);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_not_present();
    t_translate();
    t_write_dirty();
    t_readonly();
    t_back2back();
    t_priority();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule